// File: doc/BRIEF.md
# Bidirectional Handshake Byte Port

This block is one byte-wide port that carries data both ways between a host processor and a partner device over a single shared bus. It keeps one latch for each direction. A host write fills the transmit latch and lowers a ready-to-take flag toward the partner. The latch is put onto the shared pins only while the partner holds its acknowledge line low. At all other times the pins are released, so the partner can drive its own byte onto them. When the partner lowers its strobe, the byte on the pins is captured into the receive latch and a receive-full flag is raised. A host read of the port takes that byte and clears the flag.

Two interrupt enables, one for each direction, are loaded by the host. A single interrupt request combines a full receive latch with the receive enable and a consumed transmit latch with the transmit enable. A status byte packs the handshake state into fixed bit positions, so host software can poll it.

Top module: `duplex_hs_port`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold: obf_n is 1, ibf is 0, intr is 0, both interrupt enables are 0, and both data latches hold 0.
- R2: A cycle with host_wr high loads host_wdata into the transmit latch, and obf_n reads 0 from the next cycle on.
- R3: pad_oe equals the inverse of ack_n with no clock delay. pad_out always shows the transmit latch.
- R4: A cycle with ack_n low and host_wr low returns obf_n to 1 in the next cycle. When host_wr and ack_n low fall in the same cycle, the write wins and obf_n stays 0.
- R5: A cycle with stb_n low copies pad_in into the receive latch, which is seen on rx_data, and ibf reads 1 in the next cycle.
- R6: A cycle with host_rd high and stb_n high clears ibf in the next cycle and leaves rx_data unchanged. When host_rd and stb_n low fall in the same cycle, ibf stays 1.
- R7: A cycle with ie_wr high loads ie_tx_val into the transmit interrupt enable and ie_rx_val into the receive interrupt enable.
- R8: intr is 1 exactly when either (ibf and the receive enable) or (tx_done and the transmit enable) holds. tx_done is set by a cycle with ack_n low and no write, cleared by a write, and 0 after reset.
- R9: The status byte is laid out as: bit 7 obf_n, bit 6 transmit enable, bit 5 ibf, bit 4 receive enable, bit 3 intr, bits 2 to 0 always 0.
- R10: With stb_n high, changes on pad_in do not alter rx_data. An acknowledge does not alter the transmit latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe for the transmit latch |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read of the receive latch |
| ie_wr | input | 1 | Load both interrupt enables |
| ie_tx_val | input | 1 | New transmit interrupt enable |
| ie_rx_val | input | 1 | New receive interrupt enable |
| ack_n | input | 1 | Partner acknowledge, active low |
| stb_n | input | 1 | Partner strobe, active low |
| pad_in | input | 8 | Shared bus value seen at the pins |
| pad_out | output | 8 | Value to drive on the shared bus |
| pad_oe | output | 1 | Pin driver enable |
| obf_n | output | 1 | Transmit latch full, active low |
| ibf | output | 1 | Receive latch full |
| intr | output | 1 | Interrupt request |
| rx_data | output | 8 | Receive latch contents |
| status | output | 8 | Packed handshake status byte |

## Verification
The hardest states to reach are the collisions, where a host action and a partner action land in the same clock cycle. One case is a write meeting an acknowledge. The other is a read meeting a strobe. In each, one side's set must beat the other side's clear. The stimulus drives both inputs in a single cycle and checks the flag one cycle later. The interrupt request needs the tx_done term, which is only reachable after a full write-then-acknowledge sequence. The bench therefore sweeps all sixteen combinations of both enables, tx_done and ibf by building each state through the ports before it checks intr and the status byte.

// File: rtl/duplex_hs_pkg.sv
// Shared constants and helpers for the bidirectional handshake port.
// Assumes an 8-bit status byte whose bit positions are fixed by software.
package duplex_hs_pkg;
    localparam int STAT_W      = 8;
    localparam int ST_OBF_BIT  = 7;
    localparam int ST_IETX_BIT = 6;
    localparam int ST_IBF_BIT  = 5;
    localparam int ST_IERX_BIT = 4;
    localparam int ST_IRQ_BIT  = 3;

    typedef struct packed {
        logic obf_n;
        logic ie_tx;
        logic ibf;
        logic ie_rx;
        logic irq;
    } hs_state_t;

    // Pack handshake state into the status byte; low bits stay zero.
    function automatic logic [STAT_W-1:0] pack_status(input hs_state_t s);
        logic [STAT_W-1:0] v;
        v = '0;
        v[ST_OBF_BIT]  = s.obf_n;
        v[ST_IETX_BIT] = s.ie_tx;
        v[ST_IBF_BIT]  = s.ibf;
        v[ST_IERX_BIT] = s.ie_rx;
        v[ST_IRQ_BIT]  = s.irq;
        return v;
    endfunction
endpackage

// File: rtl/hs_tx_side.sv
// Transmit direction: holds the host byte, runs the full flag and
// remembers that the partner has taken the byte.
// Assumes ack_n is already synchronous to clk.
module hs_tx_side #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_n,
    output logic [DATA_W-1:0] latch_q,
    output logic              obf_n,
    output logic              done
);
    // Transmit latch, full flag and taken flag; a write beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            obf_n   <= 1'b1;
            done    <= 1'b0;
        end else if (wr) begin
            latch_q <= wdata;
            obf_n   <= 1'b0;
            done    <= 1'b0;
        end else if (!ack_n) begin
            obf_n   <= 1'b1;
            done    <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_rx_side.sv
// Receive direction: captures the bus while strobe is low and keeps
// the full flag until the host reads. Assumes stb_n is synchronous.
module hs_rx_side #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              rd,
    output logic [DATA_W-1:0] latch_q,
    output logic              ibf
);
    // Receive latch loads on strobe; strobe beats a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            ibf     <= 1'b0;
        end else if (!stb_n) begin
            latch_q <= bus_in;
            ibf     <= 1'b1;
        end else if (rd) begin
            ibf     <= 1'b0;
        end
    end
endmodule

// File: rtl/hs_irq_status.sv
// Interrupt enables, interrupt request and status packing.
// Assumes flags come straight from the direction registers.
module hs_irq_status
    import duplex_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie_wr,
    input  logic              ie_tx_val,
    input  logic              ie_rx_val,
    input  logic              obf_n,
    input  logic              tx_done,
    input  logic              ibf,
    output logic              irq,
    output logic [STAT_W-1:0] status
);
    logic ie_tx_q;
    logic ie_rx_q;
    hs_state_t st;

    // Enable registers, loaded together by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_tx_q <= 1'b0;
            ie_rx_q <= 1'b0;
        end else if (ie_wr) begin
            ie_tx_q <= ie_tx_val;
            ie_rx_q <= ie_rx_val;
        end
    end

    // Combine the two request terms and pack the status byte.
    always_comb begin
        irq      = (ibf & ie_rx_q) | (tx_done & ie_tx_q);
        st.obf_n = obf_n;
        st.ie_tx = ie_tx_q;
        st.ibf   = ibf;
        st.ie_rx = ie_rx_q;
        st.irq   = irq;
        status   = pack_status(st);
    end
endmodule

// File: rtl/duplex_hs_port.sv
// Top of the bidirectional handshake port: two latches sharing one
// set of pins, drivers enabled only while the partner acknowledges.
// Assumes partner handshake inputs are synchronous to clk.
module duplex_hs_port
    import duplex_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    input  logic              ie_wr,
    input  logic              ie_tx_val,
    input  logic              ie_rx_val,
    input  logic              ack_n,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic              pad_oe,
    output logic              obf_n,
    output logic              ibf,
    output logic              intr,
    output logic [DATA_W-1:0] rx_data,
    output logic [STAT_W-1:0] status
);
    logic tx_done;

    hs_tx_side #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
        .ack_n(ack_n), .latch_q(pad_out), .obf_n(obf_n), .done(tx_done)
    );

    hs_rx_side #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .bus_in(pad_in),
        .rd(host_rd), .latch_q(rx_data), .ibf(ibf)
    );

    hs_irq_status u_irq (
        .clk(clk), .rst_n(rst_n), .ie_wr(ie_wr), .ie_tx_val(ie_tx_val),
        .ie_rx_val(ie_rx_val), .obf_n(obf_n), .tx_done(tx_done),
        .ibf(ibf), .irq(intr), .status(status)
    );

    // Pin drivers follow the partner acknowledge directly.
    always_comb pad_oe = ~ack_n;
endmodule

// File: rtl/duplex_hs_port_chk.sv
// Checker for the handshake port, bound onto every instance of the top.
module duplex_hs_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_rd,
    input logic              ack_n,
    input logic              stb_n,
    input logic [DATA_W-1:0] pad_in,
    input logic [DATA_W-1:0] pad_out,
    input logic              obf_n,
    input logic              ibf,
    input logic              intr,
    input logic [DATA_W-1:0] rx_data,
    input logic [7:0]        status
);
    AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> !obf_n); // R2
    AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> pad_out == $past(host_wdata)); // R2
    AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (!ack_n && !host_wr) |=> obf_n); // R4
    AST_STB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) !stb_n |=> (ibf && rx_data == $past(pad_in))); // R5
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (host_rd && stb_n) |=> !ibf); // R6
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stb_n |=> $stable(rx_data)); // R10
    AST_STATUS_MAP: assert property (@(posedge clk) disable iff (!rst_n) (status[7] == obf_n && status[5] == ibf && status[3] == intr && status[2:0] == 3'b000)); // R9
endmodule

bind duplex_hs_port duplex_hs_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_duplex_hs_port.sv
module tb_duplex_hs_port;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_wr, host_rd, ie_wr, ie_tx_val, ie_rx_val, ack_n, stb_n;
    logic [7:0] host_wdata, pad_in;
    logic [7:0] pad_out, rx_data, status;
    logic       pad_oe, obf_n, ibf, intr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state computed from the requirements
    logic [7:0] m_out, m_in;
    logic m_obf_n, m_done, m_ibf, m_ietx, m_ierx;

    duplex_hs_port dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_irq();
        return (m_ibf & m_ierx) | (m_done & m_ietx);
    endfunction

    // One cycle: drive at negedge, update model at posedge, check at next negedge.
    task automatic cyc(input logic wr, input logic [7:0] wd, input logic rd,
                       input logic iew, input logic iet, input logic ier,
                       input logic ack, input logic stb, input logic [7:0] pin);
        host_wr = wr; host_wdata = wd; host_rd = rd; ie_wr = iew;
        ie_tx_val = iet; ie_rx_val = ier; ack_n = ack; stb_n = stb; pad_in = pin;
        #1;
        check("R3 oe", {7'b0, pad_oe}, {7'b0, ~ack});
        @(posedge clk);
        if (wr) begin m_out = wd; m_obf_n = 1'b0; m_done = 1'b0; end
        else if (!ack) begin m_obf_n = 1'b1; m_done = 1'b1; end
        if (!stb) begin m_in = pin; m_ibf = 1'b1; end
        else if (rd) m_ibf = 1'b0;
        if (iew) begin m_ietx = iet; m_ierx = ier; end
        @(negedge clk);
        check("R2/R4 obf_n", {7'b0, obf_n}, {7'b0, m_obf_n});
        check("R5/R6 ibf", {7'b0, ibf}, {7'b0, m_ibf});
        check("R3/R10 pad_out", pad_out, m_out);
        check("R5/R10 rx_data", rx_data, m_in);
        check("R8 intr", {7'b0, intr}, {7'b0, m_irq()});
        check("R9 status", status, {m_obf_n, m_ietx, m_ibf, m_ierx, m_irq(), 3'b000});
    endtask

    task automatic idle();
        cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, 8'hA5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        host_wr = 0; host_wdata = 0; host_rd = 0; ie_wr = 0; ie_tx_val = 0;
        ie_rx_val = 0; ack_n = 1; stb_n = 1; pad_in = 0; rst_n = 0;
        m_out = 0; m_in = 0; m_obf_n = 1; m_done = 0; m_ibf = 0; m_ietx = 0; m_ierx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 obf_n", {7'b0, obf_n}, 8'h01);
        check("R1 ibf", {7'b0, ibf}, 8'h00);
        check("R1 intr", {7'b0, intr}, 8'h00);
        check("R1 status", status, 8'h80);
        check("R1 latches", pad_out | rx_data, 8'h00);
        idle();

        // R2, R3, R4, R10: every byte out through write then acknowledge
        for (int d = 0; d < 256; d++) begin
            cyc(1, d[7:0], 0, 0, 0, 0, 1, 1, 8'h00);
            cyc(0, 8'h00, 0, 0, 0, 0, 0, 1, 8'h00);
            cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, 8'h00);
        end
        // R4: write collides with acknowledge, write wins
        cyc(1, 8'h3C, 0, 0, 0, 0, 0, 1, 8'h00);
        check("R4 collide", {7'b0, obf_n}, 8'h00);
        idle();

        // R5, R6, R10: every byte in through strobe then read
        for (int d = 0; d < 256; d++) begin
            cyc(0, 8'h00, 0, 0, 0, 0, 1, 0, d[7:0]);
            cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, ~d[7:0]);
            cyc(0, 8'h00, 1, 0, 0, 0, 1, 1, 8'h5A);
        end
        // R6: read collides with strobe, strobe wins
        cyc(0, 8'h00, 1, 0, 0, 0, 1, 0, 8'hC3);
        check("R6 collide", {7'b0, ibf}, 8'h01);
        cyc(0, 8'h00, 1, 0, 0, 0, 1, 1, 8'h00);

        // R7, R8, R9: all combinations of both enables, tx_done, ibf
        for (int k = 0; k < 16; k++) begin
            cyc(0, 8'h00, 0, 1, k[0], k[1], 1, 1, 8'h00);
            cyc(1, 8'h11, 0, 0, 0, 0, 1, 1, 8'h00);
            if (k[2]) cyc(0, 8'h00, 0, 0, 0, 0, 0, 1, 8'h00);
            if (k[3]) cyc(0, 8'h00, 0, 0, 0, 0, 1, 0, k[7:0]);
            else      cyc(0, 8'h00, 1, 0, 0, 0, 1, 1, 8'h00);
            check("R8 intr sweep", {7'b0, intr},
                  {7'b0, (k[3] & k[1]) | (k[2] & k[0])});
            check("R7 enables", {6'b0, status[6], status[4]}, {6'b0, k[0], k[1]});
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule